// File: doc/BRIEF.md
# Gapped-Clock Serial Byte Link

This block is a two-direction serial link toward a network device. The block sources the bit clock in both directions and expresses that clock as one enable per direction, high in every internal clock cycle in which one bit moves. Stopping a clock is the only signal it has. In the inbound direction a stopped clock means either "wait" or "realign", depending on how long it stays stopped. In the outbound direction a stopped clock means "nothing to send".

Inbound, the network places one bit on the data pin for each cycle in which the inbound enable is high. The block assembles bytes most significant bit first and queues them for the internal logic. It holds the inbound clock off while internal logic asks it to, through the hold input, and while its queue cannot take another byte. When the clock resumes, the block compares the number of stopped cycles with a 16-bit threshold. A stop that is longer than the threshold drops any partial byte and takes the next bit as a new most significant bit. A shorter stop keeps the bit position. Outbound, the block takes bytes from internal logic and shifts each one out most significant bit first. It keeps the outbound enable low whenever it has no bit to send.

Top module: `gapclk_serial_if`

## Requirements
- R1: After reset, `tx_clk_en` and `rx_clk_en` are low, `tx_out_valid` is low and `rx_in_ready` is high.
- R2: `tx_clk_en` in each cycle equals the value of `!tx_hold` from the previous cycle, provided the byte queue had room; one cycle of `tx_hold` high therefore gives one cycle with the clock stopped.
- R3: `tx_sdata` is captured only in cycles where `tx_clk_en` is high; values present while the clock is stopped have no effect on the bytes delivered.
- R4: Inbound bytes are assembled most significant bit first: the first captured bit of a byte lands in `tx_out_data[7]` and the eighth lands in bit 0.
- R5: If the inbound clock was stopped for more cycles than `gap_thresh` immediately before a captured bit, that bit starts a new byte as its most significant bit, and any partially assembled byte is dropped.
- R6: A stop of at most `gap_thresh` cycles keeps the bit position, so the byte continues where it left off.
- R7: The stopped-cycle count saturates at 65535 and does not wrap. With a threshold of 65535 no stop realigns. With a threshold of 65534, any stop of 65535 or more cycles realigns.
- R8: While the byte queue is full (FIFO_DEPTH bytes, with `tx_out_ready` low), `tx_clk_en` stays low. No byte is lost, and all bytes are delivered once the reader resumes.
- R9: Every byte accepted on `rx_in_valid`/`rx_in_ready` goes out on `rx_sdata` as 8 consecutive cycles with `rx_clk_en` high, most significant bit first, starting in the cycle after acceptance. When bytes are offered back to back, the enable never drops between them.
- R10: `rx_clk_en` is low in every cycle where no accepted byte still has bits left to send.
- R11: Inbound bytes come out on `tx_out_data`/`tx_out_valid`/`tx_out_ready` in the order they were received, with no extra bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; each enabled cycle carries one serial bit |
| rst | input | 1 | Synchronous active-high reset |
| gap_thresh | input | 16 | Stopped-cycle count that a stop must exceed to force realignment |
| tx_hold | input | 1 | Request from internal logic to stop the inbound clock from the next cycle |
| tx_clk_en | output | 1 | Inbound clock enable toward the network; one bit is taken per high cycle |
| tx_sdata | input | 1 | Inbound serial data from the network |
| tx_out_data | output | 8 | Oldest assembled inbound byte |
| tx_out_valid | output | 1 | An assembled byte is available |
| tx_out_ready | input | 1 | Internal logic takes the byte this cycle |
| rx_in_data | input | 8 | Byte to send outbound |
| rx_in_valid | input | 1 | `rx_in_data` holds a byte to send |
| rx_in_ready | output | 1 | The block can accept a byte this cycle |
| rx_clk_en | output | 1 | Outbound clock enable toward the network; high only while a bit is valid |
| rx_sdata | output | 1 | Outbound serial data, most significant bit first |

## Verification
The bench sweeps threshold, stop length and the bit position at which the stop falls. A design that compared with greater-or-equal, or that counted the stop one cycle off, would merge two bytes or split one at exactly the stop that equals the threshold. Two stops of 66000 cycles check saturation: a counter that wrapped would fail to realign under a threshold of 65534, and a counter that realigned on reaching its limit would wrongly realign under a threshold of 65535. With the reader stalled, the bench checks that a queue which let the clock run while full would drop bytes or reorder them. Outbound, the bench measures the length of a back-to-back burst and looks for any stopped cycle in the middle of a byte, which catches a serializer that inserts a dead cycle between bytes.

// File: rtl/gapclk_pkg.sv
package gapclk_pkg;

    localparam int BYTE_W   = 8;
    localparam int GAP_W    = 16;
    localparam int BITIDX_W = $clog2(BYTE_W);
    localparam int LEFT_W   = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [GAP_W-1:0]  gap_t;

    // One assembled byte travelling toward the queue
    typedef struct packed {
        logic  valid;
        byte_t data;
    } beat_t;

    // How a captured bit relates to the byte being assembled
    typedef enum logic {
        ALIGN_KEEP    = 1'b0,
        ALIGN_RESTART = 1'b1
    } align_e;

    // Saturating increment of the stopped-cycle count
    function automatic gap_t gap_step(gap_t g);
        return (g == '1) ? g : g + gap_t'(1);
    endfunction

endpackage

// File: rtl/gapclk_tx_deser.sv
module gapclk_tx_deser
    import gapclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  room,
    input  logic  sdata,
    input  gap_t  thresh,
    output logic  clk_en,
    output beat_t beat
);

    localparam logic [BITIDX_W-1:0] LAST_IDX = BITIDX_W'(BYTE_W - 1);

    gap_t                gap_cnt;
    byte_t               acc;
    logic [BITIDX_W-1:0] ncol;
    align_e              mode;

    always_comb begin
        mode = (clk_en && (gap_cnt > thresh)) ? ALIGN_RESTART : ALIGN_KEEP;
        beat.valid = clk_en && (mode == ALIGN_KEEP) && (ncol == LAST_IDX);
        beat.data  = {acc[BYTE_W-2:0], sdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en  <= 1'b0;
            gap_cnt <= '0;
            acc     <= '0;
            ncol    <= '0;
        end else begin
            clk_en <= !hold && room;
            if (clk_en) begin
                gap_cnt <= '0;
                acc     <= {acc[BYTE_W-2:0], sdata};
                if (mode == ALIGN_RESTART) begin
                    ncol <= BITIDX_W'(1);
                end else if (ncol == LAST_IDX) begin
                    ncol <= '0;
                end else begin
                    ncol <= ncol + BITIDX_W'(1);
                end
            end else begin
                gap_cnt <= gap_step(gap_cnt);
            end
        end
    end

endmodule

// File: rtl/gapclk_byte_fifo.sv
module gapclk_byte_fifo
    import gapclk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t wr,
    input  logic  rd_ready,
    output byte_t rd_data,
    output logic  rd_valid,
    output logic  room
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             pop;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        rd_valid = (cnt != '0);
        rd_data  = mem[rd_ptr];
        pop      = rd_valid && rd_ready;
        cnt_next = cnt + CNT_W'(wr.valid) - CNT_W'(pop);
        room     = (cnt_next < CNT_W'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            cnt <= cnt_next;
            if (wr.valid) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr.valid) begin
            mem[wr_ptr] <= wr.data;
        end
    end

endmodule

// File: rtl/gapclk_rx_ser.sv
module gapclk_rx_ser
    import gapclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t in_data,
    input  logic  in_valid,
    output logic  in_ready,
    output logic  clk_en,
    output logic  sdata
);

    byte_t             sh;
    logic [LEFT_W-1:0] left;

    always_comb begin
        in_ready = (left <= LEFT_W'(1));
        clk_en   = (left != '0);
        sdata    = sh[BYTE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (in_valid && in_ready) begin
            sh   <= in_data;
            left <= LEFT_W'(BYTE_W);
        end else if (left != '0) begin
            sh   <= {sh[BYTE_W-2:0], 1'b0};
            left <= left - LEFT_W'(1);
        end
    end

endmodule

// File: rtl/gapclk_serial_if.sv
module gapclk_serial_if
    import gapclk_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [gapclk_pkg::GAP_W-1:0]  gap_thresh,
    input  logic                          tx_hold,
    output logic                          tx_clk_en,
    input  logic                          tx_sdata,
    output logic [gapclk_pkg::BYTE_W-1:0] tx_out_data,
    output logic                          tx_out_valid,
    input  logic                          tx_out_ready,
    input  logic [gapclk_pkg::BYTE_W-1:0] rx_in_data,
    input  logic                          rx_in_valid,
    output logic                          rx_in_ready,
    output logic                          rx_clk_en,
    output logic                          rx_sdata
);

    beat_t tx_beat;
    logic  q_room;

    gapclk_tx_deser u_tx (
        .clk    (clk),
        .rst    (rst),
        .hold   (tx_hold),
        .room   (q_room),
        .sdata  (tx_sdata),
        .thresh (gap_thresh),
        .clk_en (tx_clk_en),
        .beat   (tx_beat)
    );

    gapclk_byte_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr       (tx_beat),
        .rd_ready (tx_out_ready),
        .rd_data  (tx_out_data),
        .rd_valid (tx_out_valid),
        .room     (q_room)
    );

    gapclk_rx_ser u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_data  (rx_in_data),
        .in_valid (rx_in_valid),
        .in_ready (rx_in_ready),
        .clk_en   (rx_clk_en),
        .sdata    (rx_sdata)
    );

endmodule

// File: rtl/gapclk_serial_if_chk.sv
module gapclk_serial_if_chk
    import gapclk_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               tx_hold,
    input logic                               tx_clk_en,
    input logic                               rx_in_valid,
    input logic                               rx_in_ready,
    input logic [BYTE_W-1:0]                  rx_in_data,
    input logic                               rx_clk_en,
    input logic                               rx_sdata,
    input logic [GAP_W-1:0]                   gap_cnt,
    input logic [$clog2(FIFO_DEPTH+1)-1:0]    fifo_cnt,
    input logic [BYTE_W-1:0]                  acc,
    input logic [BITIDX_W-1:0]                ncol
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_clk_en && !rx_clk_en));

    // R2
    hold_stops_clk_chk: assert property (@(posedge clk) disable iff (rst)
        tx_hold |=> !tx_clk_en);

    // R3
    gap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_clk_en |=> ($stable(acc) && $stable(ncol)));

    // R7
    gap_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_clk_en && (gap_cnt == '1)) |=> (gap_cnt == '1));

    // R8
    full_gates_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)) |-> !tx_clk_en);

    // R9
    rx_msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_in_valid && rx_in_ready) |=> (rx_clk_en && (rx_sdata == $past(rx_in_data[BYTE_W-1]))));

    // R10
    rx_idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_in_ready && !rx_in_valid) |=> !rx_clk_en);

endmodule

bind gapclk_serial_if gapclk_serial_if_chk #(
    .FIFO_DEPTH (FIFO_DEPTH)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tx_hold     (tx_hold),
    .tx_clk_en   (tx_clk_en),
    .rx_in_valid (rx_in_valid),
    .rx_in_ready (rx_in_ready),
    .rx_in_data  (rx_in_data),
    .rx_clk_en   (rx_clk_en),
    .rx_sdata    (rx_sdata),
    .gap_cnt     (u_tx.gap_cnt),
    .fifo_cnt    (u_fifo.cnt),
    .acc         (u_tx.acc),
    .ncol        (u_tx.ncol)
);

// File: tb/gapclk_serial_if_tb_top.sv
module gapclk_serial_if_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] gap_thresh = '0;
    logic        tx_hold = 1'b1;
    logic        tx_clk_en;
    logic        tx_sdata = 1'b0;
    logic [7:0]  tx_out_data;
    logic        tx_out_valid;
    logic        tx_out_ready = 1'b1;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_valid = 1'b0;
    logic        rx_in_ready;
    logic        rx_clk_en;
    logic        rx_sdata;

    always #5 clk = ~clk;

    gapclk_serial_if #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .gap_thresh   (gap_thresh),
        .tx_hold      (tx_hold),
        .tx_clk_en    (tx_clk_en),
        .tx_sdata     (tx_sdata),
        .tx_out_data  (tx_out_data),
        .tx_out_valid (tx_out_valid),
        .tx_out_ready (tx_out_ready),
        .rx_in_data   (rx_in_data),
        .rx_in_valid  (rx_in_valid),
        .rx_in_ready  (rx_in_ready),
        .rx_clk_en    (rx_clk_en),
        .rx_sdata     (rx_sdata)
    );

    typedef struct { logic b; int gap; } tbit_t;
    typedef struct { logic [7:0] v; int dly; } rxent_t;

    tbit_t      bq[$];
    logic [7:0] txexp[$];
    rxent_t     rq[$];
    logic [7:0] rxexp[$];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  drv_on = 0;
    bit  rx_hs = 0;
    int  cyc = 0;
    int  rx_first = -1;
    int  rx_last = -1;
    int  rx_holes = 0;
    int  rx_en_cnt = 0;
    int  rnb = 0;
    logic [7:0] rsh = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add_bits(input logic [7:0] v, input int hi, input int lo, input int g);
        for (int i = hi; i >= lo; i--) begin
            bq.push_back('{b: v[i], gap: (i == hi) ? g : 0});
        end
    endtask

    task automatic drain_tx();
        while (bq.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    // Inbound network model: one bit per enabled cycle, junk while stopped
    always @(negedge clk) begin
        if (drv_on) begin
            if (tx_clk_en && bq.size() > 0) begin
                tx_sdata = bq.pop_front().b;
            end else begin
                tx_sdata = ~tx_sdata;
            end
            if (bq.size() == 0) begin
                tx_hold = 1'b1;
            end else if (bq[0].gap > 0) begin
                bq[0].gap = bq[0].gap - 1;
                tx_hold = 1'b1;
            end else begin
                tx_hold = 1'b0;
            end
        end
    end

    // Inbound byte sink: R4 R11
    always @(negedge clk) begin
        if (!rst && tx_out_valid && tx_out_ready) begin
            if (txexp.size() == 0) begin
                check(1'b0, "R11 unexpected byte", int'(tx_out_data), 0);
            end else begin
                check(tx_out_data == txexp[0], "R4 R11 inbound byte", int'(tx_out_data), int'(txexp[0]));
                void'(txexp.pop_front());
            end
        end
    end

    // Outbound byte source
    always @(negedge clk) begin
        if (rx_hs) void'(rq.pop_front());
        rx_in_valid = 1'b0;
        if (rq.size() > 0) begin
            if (rq[0].dly > 0) begin
                rq[0].dly = rq[0].dly - 1;
            end else begin
                rx_in_valid = 1'b1;
                rx_in_data  = rq[0].v;
            end
        end
        rx_hs = rx_in_valid && rx_in_ready;
    end

    // Outbound network model: R9 R10
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rx_clk_en) begin
                rsh = {rsh[6:0], rx_sdata};
                rnb++;
                rx_en_cnt++;
                if (rx_first < 0) rx_first = cyc;
                rx_last = cyc;
                if (rnb == 8) begin
                    rnb = 0;
                    if (rxexp.size() == 0) begin
                        check(1'b0, "R10 unexpected outbound byte", int'(rsh), 0);
                    end else begin
                        check(rsh == rxexp[0], "R9 outbound byte", int'(rsh), int'(rxexp[0]));
                        void'(rxexp.pop_front());
                    end
                end
            end else if (rnb != 0) begin
                rx_holes++;
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] a;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_clk_en == 1'b0,    "R1 tx_clk_en", int'(tx_clk_en), 0);
        check(rx_clk_en == 1'b0,    "R1 rx_clk_en", int'(rx_clk_en), 0);
        check(tx_out_valid == 1'b0, "R1 tx_out_valid", int'(tx_out_valid), 0);
        check(rx_in_ready == 1'b1,  "R1 rx_in_ready", int'(rx_in_ready), 1);

        // R2 hold to enable, one cycle later
        tx_hold = 1'b0;
        @(negedge clk);
        check(tx_clk_en == 1'b1, "R2 enable after hold low", int'(tx_clk_en), 1);
        tx_hold = 1'b1;
        @(negedge clk);
        check(tx_clk_en == 1'b0, "R2 stop after hold high", int'(tx_clk_en), 0);
        repeat (10) @(negedge clk);
        drv_on = 1;

        // R4 R3: contiguous bytes, junk driven on every stopped cycle
        gap_thresh = 16'd2;
        for (int i = 0; i < 8; i++) begin
            a = 8'(i * 29 + 7);
            add_bits(a, 7, 0, 0);
            txexp.push_back(a);
        end
        drain_tx();

        // R6 R3: short stops at every bit position keep alignment
        gap_thresh = 16'd5;
        for (int i = 0; i < 6; i++) begin
            a = 8'(i * 53 + 100);
            for (int k = 7; k >= 0; k--) begin
                bq.push_back('{b: a[k], gap: (7 - k + i) % 6});
            end
            txexp.push_back(a);
        end
        drain_tx();

        // R5 R6 sweep: threshold x stop length x bit position
        for (int t = 0; t < 4; t++) begin
            gap_thresh = 16'(t);
            for (int g = 1; g <= 5; g++) begin
                for (int p = 1; p <= 7; p++) begin
                    a = 8'(t * 50 + g * 7 + p) ^ 8'h5A;
                    b = ~a;
                    add_bits(a, 7, 8 - p, 0);
                    if (g > t) begin
                        add_bits(b, 7, 0, g);   // R5 realign
                        txexp.push_back(b);
                    end else begin
                        add_bits(a, 7 - p, 0, g); // R6 keep
                        txexp.push_back(a);
                    end
                    drain_tx();
                end
            end
        end

        // R8: reader stalled, queue fills, clock stays stopped, no loss
        gap_thresh = 16'd3;
        @(posedge clk); #2 tx_out_ready = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            a = 8'(i * 17 + 200);
            add_bits(a, 7, 0, 0);
            txexp.push_back(a);
        end
        repeat (8 * DEPTH + 40) @(negedge clk);
        check(tx_clk_en == 1'b0, "R8 clock stopped while full", int'(tx_clk_en), 0);
        check(tx_out_valid == 1'b1, "R8 bytes held", int'(tx_out_valid), 1);
        check(bq.size() == 16, "R8 bits left unsent", bq.size(), 16);
        @(posedge clk); #2 tx_out_ready = 1'b1;
        drain_tx();

        // R7: saturating stop count
        gap_thresh = 16'hFFFF;
        add_bits(8'hB6, 7, 5, 0);
        add_bits(8'hB6, 4, 0, 66000);
        txexp.push_back(8'hB6);
        drain_tx();
        gap_thresh = 16'hFFFE;
        add_bits(8'hFF, 7, 5, 0);
        add_bits(8'h3C, 7, 0, 66000);
        txexp.push_back(8'h3C);
        drain_tx();
        check(txexp.size() == 0, "R7 R11 all inbound bytes seen", txexp.size(), 0);

        // R9: back-to-back outbound burst never stops mid-stream
        rx_first = -1;
        for (int i = 0; i < 6; i++) begin
            a = 8'(i * 41 + 3);
            rq.push_back('{v: a, dly: 0});
            rxexp.push_back(a);
        end
        while (rq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(rx_last - rx_first + 1 == 48, "R9 burst length", rx_last - rx_first + 1, 48);

        // R9 R10: outbound with idle spacing
        rq.push_back('{v: 8'h81, dly: 3});
        rq.push_back('{v: 8'h7E, dly: 0});
        rq.push_back('{v: 8'hC3, dly: 7});
        rq.push_back('{v: 8'h01, dly: 1});
        rxexp.push_back(8'h81);
        rxexp.push_back(8'h7E);
        rxexp.push_back(8'hC3);
        rxexp.push_back(8'h01);
        while (rq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        rx_en_cnt = 0;
        repeat (30) @(negedge clk);
        check(rx_en_cnt == 0, "R10 idle clock stopped", rx_en_cnt, 0);
        check(rx_holes == 0, "R9 no mid-byte stop", rx_holes, 0);
        check(rxexp.size() == 0, "R9 all outbound bytes seen", rxexp.size(), 0);

        summary();
        $finish;
    end

endmodule